// File: doc/BRIEF.md
# OLED Controller Initialization Sequencer

This block brings up a monochrome OLED display controller that listens on a byte-wide command link with a data/command select line. A one-cycle start pulse makes it pull the panel reset low for a programmable number of cycles. It then waits the same number of cycles for the panel to recover. After that it streams a fixed list of command bytes toward a serializer over a valid/ready byte handshake.

Several bytes in the list depend on two configuration inputs: the panel height (64 or 32 rows) and whether the image is turned by 180 degrees. Both inputs are captured on the start pulse. Every byte, including the parameter bytes that follow an opcode, is a separate transfer with the data/command select held at the command level.

Once the list has gone out, the block serves later requests. These are blanking, unblanking, a contrast change, and the address-window preamble that comes before each frame of pixel data. Requests that arrive before or during bring-up are held and served when bring-up ends.

Top module: `oled_boot_seq`

## Requirements
- R1: On reset, `panel_rst_n_o` is 1 and `cmd_valid_o`, `busy_o` and `init_done_o` are 0. After `start_i`, `panel_rst_n_o` is 0 for exactly RST_CYCLES cycles and then 1 for RST_CYCLES recovery cycles before the first command byte. No byte is offered while the panel reset is low.
- R2: `dc_o` is 0 whenever `cmd_valid_o` is 1. `dc_o` is 1 only when the block is idle after a completed bring-up, which marks the link free for pixel data.
- R3: The bring-up list is 23 bytes, in this order: AE, D5, 80, A8, mux, D3, 00, 40, 8D, 14, 20, 01, seg, scan, DA, pins, D9, F1, A4, A6, AF, 81, contrast (hex). Each byte completes its own handshake.
- R4: Height selects three bytes. With `cfg_tall_i`=1 (64 rows), mux=3F, pins=12 and contrast=CF. With `cfg_tall_i`=0 (32 rows), mux=1F, pins=02 and contrast=8F.
- R5: Rotation selects two bytes. With `cfg_flip_i`=1, seg=A0 and scan=C8. With `cfg_flip_i`=0, seg=A1 and scan=C0. Both configuration inputs are sampled on the start pulse.
- R6: A contrast request sends 81 followed by the requested value. If a second contrast request comes while one is still waiting, the newer value replaces the older.
- R7: A blank request sends AE and an unblank request sends AF. If both arrive in the same cycle, blank wins. A later blank or unblank request replaces an earlier one that is still waiting.
- R8: A frame request sends three bytes: the low column (04 unrotated, 00 rotated), then 10, then 40.
- R9: Requests that arrive before or during bring-up are held. They are served after bring-up in the order blank/unblank, then contrast, then frame window.
- R10: `busy_o` is 1 from the start pulse until the last byte of bring-up or of the last waiting request has been accepted. `init_done_o` rises when bring-up ends.
- R11: While `cmd_valid_o` is 1 and `cmd_ready_i` is 0, the block holds `cmd_valid_o` and `cmd_byte_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse: start or restart bring-up |
| cfg_tall_i | input | 1 | 1 = 64-row panel, 0 = 32-row panel |
| cfg_flip_i | input | 1 | 1 = image turned by 180 degrees |
| blank_req_i | input | 1 | Pulse: blank the panel |
| unblank_req_i | input | 1 | Pulse: unblank the panel |
| contrast_req_i | input | 1 | Pulse: load a new contrast value |
| contrast_val_i | input | 8 | Contrast value, sampled with the request |
| frame_req_i | input | 1 | Pulse: send the address-window preamble |
| panel_rst_n_o | output | 1 | Panel reset, active low |
| cmd_valid_o | output | 1 | Command byte offered |
| cmd_ready_i | input | 1 | Serializer accepts the byte |
| cmd_byte_o | output | 8 | Command byte |
| dc_o | output | 1 | Data/command select, 0 = command |
| busy_o | output | 1 | Commands in progress or waiting |
| init_done_o | output | 1 | Bring-up has completed |

## Verification
A wrong step index or state shows up at the very next handshake as a wrong byte in the stream. The scoreboard compares every accepted byte against a list built from the requirements, so such an error is caught within one transfer. A wrong configuration capture or a wrong request priority also reaches the ports within a few bytes, as a substituted byte or a reordered group. A wrong reset-timer count shows up as a wrong count of low or recovery cycles on the panel reset before the first byte.

// File: rtl/oled_seq_pkg.sv
package oled_seq_pkg;
    localparam int INIT_LEN = 23;
    localparam int IDX_W    = $clog2(INIT_LEN);

    typedef enum logic [2:0] {
        ST_IDLE, ST_RLOW, ST_RREC, ST_INIT, ST_RDY, ST_SVC
    } seq_st_e;

    typedef enum logic [1:0] {
        SVC_BLK, SVC_CON, SVC_WIN
    } svc_e;

    function automatic logic [7:0] init_byte(logic [IDX_W-1:0] i, logic tall, logic flip);
        logic [7:0] b;
        case (i)
            5'd0:  b = 8'hAE;
            5'd1:  b = 8'hD5;
            5'd2:  b = 8'h80;
            5'd3:  b = 8'hA8;
            5'd4:  b = tall ? 8'h3F : 8'h1F;
            5'd5:  b = 8'hD3;
            5'd6:  b = 8'h00;
            5'd7:  b = 8'h40;
            5'd8:  b = 8'h8D;
            5'd9:  b = 8'h14;
            5'd10: b = 8'h20;
            5'd11: b = 8'h01;
            5'd12: b = flip ? 8'hA0 : 8'hA1;
            5'd13: b = flip ? 8'hC8 : 8'hC0;
            5'd14: b = 8'hDA;
            5'd15: b = tall ? 8'h12 : 8'h02;
            5'd16: b = 8'hD9;
            5'd17: b = 8'hF1;
            5'd18: b = 8'hA4;
            5'd19: b = 8'hA6;
            5'd20: b = 8'hAF;
            5'd21: b = 8'h81;
            5'd22: b = tall ? 8'hCF : 8'h8F;
            default: b = 8'hE3;
        endcase
        return b;
    endfunction

    function automatic logic [7:0] win_byte(logic [IDX_W-1:0] i, logic flip);
        logic [7:0] b;
        case (i)
            5'd0:    b = flip ? 8'h00 : 8'h04;
            5'd1:    b = 8'h10;
            default: b = 8'h40;
        endcase
        return b;
    endfunction

    function automatic logic [IDX_W-1:0] svc_last(svc_e k);
        logic [IDX_W-1:0] l;
        case (k)
            SVC_BLK: l = IDX_W'(0);
            SVC_CON: l = IDX_W'(1);
            default: l = IDX_W'(2);
        endcase
        return l;
    endfunction
endpackage

// File: rtl/oled_rst_timer.sv
module oled_rst_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic done_o
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = CW'(CYCLES - 1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == '0);

    // R1: a reload always starts a full window, so done drops next cycle
    p_reload_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (!done_o || (CYCLES == 1)));
endmodule

// File: rtl/oled_req_hold.sv
module oled_req_hold (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       blank_req_i,
    input  logic       unblank_req_i,
    input  logic       con_req_i,
    input  logic [7:0] con_val_i,
    input  logic       win_req_i,
    input  logic       clr_blk_i,
    input  logic       clr_con_i,
    input  logic       clr_win_i,
    output logic       pend_blk_o,
    output logic       blk_on_o,
    output logic       pend_con_o,
    output logic [7:0] con_val_o,
    output logic       pend_win_o
);
    typedef struct packed {
        logic       pblk;
        logic       blk_on;
        logic       pcon;
        logic [7:0] cval;
        logic       pwin;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (clr_blk_i) h_d.pblk = 1'b0;
        if (clr_con_i) h_d.pcon = 1'b0;
        if (clr_win_i) h_d.pwin = 1'b0;
        if (blank_req_i || unblank_req_i) begin
            h_d.pblk   = 1'b1;
            h_d.blk_on = blank_req_i;
        end
        if (con_req_i) begin
            h_d.pcon = 1'b1;
            h_d.cval = con_val_i;
        end
        if (win_req_i) h_d.pwin = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign pend_blk_o = h_q.pblk;
    assign blk_on_o   = h_q.blk_on;
    assign pend_con_o = h_q.pcon;
    assign con_val_o  = h_q.cval;
    assign pend_win_o = h_q.pwin;

    // R7: blank beats unblank in the same cycle
    p_blank_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        blank_req_i |=> (pend_blk_o && blk_on_o));
    // R9: a held request stays until the sequencer takes it
    p_con_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_con_o && !clr_con_i) |=> pend_con_o);
endmodule

// File: rtl/oled_boot_seq.sv
module oled_boot_seq
    import oled_seq_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       cfg_tall_i,
    input  logic       cfg_flip_i,
    input  logic       blank_req_i,
    input  logic       unblank_req_i,
    input  logic       contrast_req_i,
    input  logic [7:0] contrast_val_i,
    input  logic       frame_req_i,
    output logic       panel_rst_n_o,
    output logic       cmd_valid_o,
    input  logic       cmd_ready_i,
    output logic [7:0] cmd_byte_o,
    output logic       dc_o,
    output logic       busy_o,
    output logic       init_done_o
);
    typedef struct packed {
        seq_st_e          st;
        logic [IDX_W-1:0] idx;
        svc_e             kind;
        logic [7:0]       cap;
        logic             tall;
        logic             flip;
        logic             done;
    } ctl_t;

    ctl_t c_d, c_q;

    logic       tmr_load, tmr_done;
    logic       clr_blk, clr_con, clr_win;
    logic       pend_blk, blk_on, pend_con, pend_win;
    logic [7:0] con_val;
    logic       any_pend;

    oled_rst_timer #(.CYCLES(RST_CYCLES)) tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .done_o (tmr_done)
    );

    oled_req_hold hold_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .blank_req_i   (blank_req_i),
        .unblank_req_i (unblank_req_i),
        .con_req_i     (contrast_req_i),
        .con_val_i     (contrast_val_i),
        .win_req_i     (frame_req_i),
        .clr_blk_i     (clr_blk),
        .clr_con_i     (clr_con),
        .clr_win_i     (clr_win),
        .pend_blk_o    (pend_blk),
        .blk_on_o      (blk_on),
        .pend_con_o    (pend_con),
        .con_val_o     (con_val),
        .pend_win_o    (pend_win)
    );

    assign any_pend = pend_blk || pend_con || pend_win;

    always_comb begin
        c_d      = c_q;
        tmr_load = 1'b0;
        clr_blk  = 1'b0;
        clr_con  = 1'b0;
        clr_win  = 1'b0;
        case (c_q.st)
            ST_IDLE, ST_RDY: begin
                if (start_i) begin
                    c_d.st   = ST_RLOW;
                    c_d.tall = cfg_tall_i;
                    c_d.flip = cfg_flip_i;
                    c_d.done = 1'b0;
                    tmr_load = 1'b1;
                end else if (c_q.st == ST_RDY) begin
                    c_d.idx = '0;
                    if (pend_blk) begin
                        c_d.st   = ST_SVC;
                        c_d.kind = SVC_BLK;
                        c_d.cap  = blk_on ? 8'hAE : 8'hAF;
                        clr_blk  = 1'b1;
                    end else if (pend_con) begin
                        c_d.st   = ST_SVC;
                        c_d.kind = SVC_CON;
                        c_d.cap  = con_val;
                        clr_con  = 1'b1;
                    end else if (pend_win) begin
                        c_d.st   = ST_SVC;
                        c_d.kind = SVC_WIN;
                        clr_win  = 1'b1;
                    end
                end
            end
            ST_RLOW: begin
                if (tmr_done) begin
                    c_d.st   = ST_RREC;
                    tmr_load = 1'b1;
                end
            end
            ST_RREC: begin
                if (tmr_done) begin
                    c_d.st  = ST_INIT;
                    c_d.idx = '0;
                end
            end
            ST_INIT: begin
                if (cmd_ready_i) begin
                    if (c_q.idx == IDX_W'(INIT_LEN - 1)) begin
                        c_d.st   = ST_RDY;
                        c_d.done = 1'b1;
                    end else begin
                        c_d.idx = c_q.idx + 1'b1;
                    end
                end
            end
            ST_SVC: begin
                if (cmd_ready_i) begin
                    if (c_q.idx == svc_last(c_q.kind))
                        c_d.st = ST_RDY;
                    else
                        c_d.idx = c_q.idx + 1'b1;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, kind: SVC_BLK, default: '0};
        else        c_q <= c_d;
    end

    always_comb begin
        cmd_byte_o = 8'h00;
        if (c_q.st == ST_INIT) begin
            cmd_byte_o = init_byte(c_q.idx, c_q.tall, c_q.flip);
        end else if (c_q.st == ST_SVC) begin
            case (c_q.kind)
                SVC_BLK: cmd_byte_o = c_q.cap;
                SVC_CON: cmd_byte_o = (c_q.idx == '0) ? 8'h81 : c_q.cap;
                default: cmd_byte_o = win_byte(c_q.idx, c_q.flip);
            endcase
        end
    end

    assign cmd_valid_o   = (c_q.st == ST_INIT) || (c_q.st == ST_SVC);
    assign panel_rst_n_o = (c_q.st != ST_RLOW);
    assign dc_o          = (c_q.st == ST_RDY);
    assign busy_o        = !((c_q.st == ST_IDLE) || ((c_q.st == ST_RDY) && !any_pend));
    assign init_done_o   = c_q.done;

    // R2: every offered byte is a command byte
    p_dc_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> !dc_o);
    // R11: a stalled byte is held unchanged
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_byte_o)));
    // R1: nothing is offered while the panel is in reset
    p_quiet_rst_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !panel_rst_n_o |-> !cmd_valid_o);
    // R10: offering a byte implies busy
    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> busy_o);
    // R10: accepting the final bring-up byte raises done
    p_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_ready_i && !init_done_o && cmd_byte_o != 8'h81
         && $past(cmd_byte_o) == 8'h81 && $past(cmd_valid_o)) |=> init_done_o);
endmodule

// File: tb/oled_boot_seq_tb_top.sv
module oled_boot_seq_tb_top;
    localparam int RC = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, cfg_tall_i = 1'b1, cfg_flip_i = 1'b0;
    logic       blank_req_i = 1'b0, unblank_req_i = 1'b0;
    logic       contrast_req_i = 1'b0, frame_req_i = 1'b0;
    logic [7:0] contrast_val_i = 8'h00;
    logic       cmd_ready_i = 1'b0;
    logic       panel_rst_n_o, cmd_valid_o, dc_o, busy_o, init_done_o;
    logic [7:0] cmd_byte_o;

    always #5 clk = ~clk;

    oled_boot_seq #(.RST_CYCLES(RC)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .cfg_tall_i(cfg_tall_i), .cfg_flip_i(cfg_flip_i),
        .blank_req_i(blank_req_i), .unblank_req_i(unblank_req_i),
        .contrast_req_i(contrast_req_i), .contrast_val_i(contrast_val_i),
        .frame_req_i(frame_req_i), .panel_rst_n_o(panel_rst_n_o),
        .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
        .cmd_byte_o(cmd_byte_o), .dc_o(dc_o), .busy_o(busy_o),
        .init_done_o(init_done_o)
    );

    int         n_cmp = 0, n_bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    int         lo_cnt = 0, rec_cnt = 0;
    logic [7:0] lf = 8'hA5;
    logic       prev_stall = 1'b0;
    logic [7:0] prev_byte = 8'h00;
    bit         finished = 0;

    task automatic chk(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(logic [7:0] b, string tag);
        exp_q.push_back(b);
        tag_q.push_back(tag);
    endtask

    // monitor: drives ready, pops and compares accepted bytes
    initial begin
        forever begin
            @(negedge clk);
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            cmd_ready_i = rst_n && (lf[0] | lf[1]);
            #1;
            if (!panel_rst_n_o) lo_cnt++;
            if (panel_rst_n_o && busy_o && !cmd_valid_o && !init_done_o) rec_cnt++;
            if (prev_stall)
                chk(cmd_valid_o && cmd_byte_o == prev_byte, "R11 hold", int'(cmd_byte_o), int'(prev_byte));
            if (cmd_valid_o && dc_o) chk(0, "R2 dc low", 1, 0);
            if (cmd_valid_o && !panel_rst_n_o) chk(0, "R1 quiet in reset", 1, 0);
            if (cmd_valid_o && cmd_ready_i) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R3 unexpected byte", int'(cmd_byte_o), 0);
                end else begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    automatic string      t = tag_q.pop_front();
                    chk(cmd_byte_o == e, t, int'(cmd_byte_o), int'(e));
                end
            end
            prev_stall = cmd_valid_o && !cmd_ready_i;
            prev_byte  = cmd_byte_o;
        end
    end

    task automatic push_init(bit tall, bit flip);
        logic [7:0] l [23];
        l = '{8'hAE, 8'hD5, 8'h80, 8'hA8, 8'h00, 8'hD3, 8'h00, 8'h40,
              8'h8D, 8'h14, 8'h20, 8'h01, 8'h00, 8'h00, 8'hDA, 8'h00,
              8'hD9, 8'hF1, 8'hA4, 8'hA6, 8'hAF, 8'h81, 8'h00};
        l[4]  = tall ? 8'h3F : 8'h1F;
        l[15] = tall ? 8'h12 : 8'h02;
        l[22] = tall ? 8'hCF : 8'h8F;
        l[12] = flip ? 8'hA0 : 8'hA1;
        l[13] = flip ? 8'hC8 : 8'hC0;
        for (int i = 0; i < 23; i++) begin
            if (i == 4 || i == 15 || i == 22) push(l[i], "R4 height byte");
            else if (i == 12 || i == 13)    push(l[i], "R5 rotation byte");
            else                            push(l[i], "R3 bring-up byte");
        end
    endtask

    task automatic pulse_start(bit tall, bit flip);
        @(negedge clk);
        cfg_tall_i = tall; cfg_flip_i = flip; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cfg_tall_i = ~tall; cfg_flip_i = ~flip;   // R5: only the start sample counts
    endtask

    task automatic drain();
        do @(negedge clk); while (exp_q.size() != 0 || busy_o || cmd_valid_o);
        #2;
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2;
        chk(panel_rst_n_o == 1'b1, "R1 reset panel_rst_n", int'(panel_rst_n_o), 1);
        chk(cmd_valid_o == 1'b0, "R1 reset valid", int'(cmd_valid_o), 0);
        chk(busy_o == 1'b0, "R10 reset busy", int'(busy_o), 0);
        chk(init_done_o == 1'b0, "R10 reset done", int'(init_done_o), 0);
        rst_n = 1'b1;

        // bring-up, 64 rows, unrotated, with requests during bring-up
        lo_cnt = 0; rec_cnt = 0;
        push_init(1'b1, 1'b0);
        push(8'hAE, "R9 held blank first");
        push(8'h81, "R9 held contrast second");
        push(8'h55, "R9 held contrast value");
        push(8'h04, "R9 held window third");
        push(8'h10, "R8 window high column");
        push(8'h40, "R8 window start line");
        pulse_start(1'b1, 1'b0);
        #2 chk(busy_o == 1'b1, "R10 busy after start", int'(busy_o), 1);
        repeat (RC + 4) @(negedge clk);
        frame_req_i = 1'b1; blank_req_i = 1'b1;
        contrast_req_i = 1'b1; contrast_val_i = 8'h55;
        @(negedge clk);
        frame_req_i = 1'b0; blank_req_i = 1'b0; contrast_req_i = 1'b0;
        drain();
        chk(lo_cnt == RC, "R1 reset low cycles", lo_cnt, RC);
        chk(rec_cnt == RC, "R1 recovery cycles", rec_cnt, RC);
        chk(init_done_o == 1'b1, "R10 done after bring-up", int'(init_done_o), 1);
        chk(busy_o == 1'b0, "R10 idle after drain", int'(busy_o), 0);
        chk(dc_o == 1'b1, "R2 dc high when idle", int'(dc_o), 1);

        // unblank and contrast in idle
        push(8'hAF, "R7 unblank");
        pulse(unblank_req_i);
        drain();
        push(8'h81, "R6 contrast opcode");
        push(8'h00, "R6 contrast value");
        @(negedge clk); contrast_val_i = 8'h00; contrast_req_i = 1'b1;
        @(negedge clk); contrast_req_i = 1'b0;
        drain();

        // blank and unblank together: blank wins
        push(8'hAE, "R7 blank wins");
        @(negedge clk); blank_req_i = 1'b1; unblank_req_i = 1'b1;
        @(negedge clk); blank_req_i = 1'b0; unblank_req_i = 1'b0;
        drain();

        // newer contrast replaces a waiting one
        push(8'h04, "R8 window low column unrotated");
        push(8'h10, "R8 window high column");
        push(8'h40, "R8 window start line");
        push(8'h81, "R6 contrast opcode");
        push(8'h22, "R6 newer contrast replaces older");
        @(negedge clk); frame_req_i = 1'b1;
        @(negedge clk); frame_req_i = 1'b0; contrast_req_i = 1'b1; contrast_val_i = 8'h11;
        @(negedge clk); contrast_val_i = 8'h22;
        @(negedge clk); contrast_req_i = 1'b0;
        drain();

        // re-bring-up, 32 rows, rotated
        lo_cnt = 0; rec_cnt = 0;
        push_init(1'b0, 1'b1);
        pulse_start(1'b0, 1'b1);
        #2 chk(init_done_o == 1'b0, "R10 done cleared on restart", int'(init_done_o), 0);
        drain();
        chk(lo_cnt == RC, "R1 reset low cycles again", lo_cnt, RC);
        push(8'h00, "R8 window low column rotated");
        push(8'h10, "R8 window high column");
        push(8'h40, "R8 window start line");
        pulse(frame_req_i);
        drain();
        chk(exp_q.size() == 0, "R3 all expected bytes seen", exp_q.size(), 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule